// File: doc/BRIEF.md
# Zig-Zag Inverse Corner Decoder

This block sits in front of one beam driver and turns a stream of corner flags back into the binary pixels of one image block. Symbols arrive one per clock in the same serpentine order in which the beam writes: one row left to right, the next right to left, and so on to the bottom of the block. For every symbol accepted, the decoder produces one pixel value together with the column and row it belongs to, so the driver never has to reorder anything.

Two pieces of state rebuild the image. A horizontal fill flag opens and closes runs along the current row. A row buffer, one bit per column and addressed by the current column, carries vertical edges from one row to the next. The same per-pixel rule works whichever way the row runs: a corner flips the fill flag, the flag is folded into the buffer bit for that column, and the result is both the new buffer bit and the pixel. A run therefore covers its opening corner and stops one pixel short of its closing corner.

The block width and height are parameters. Symbols enter through a valid/ready pair and pixels leave through a one-deep registered valid/ready stage, so a slow driver stalls the stream without losing decoder state. The last pixel of a block carries an end-of-block flag, and the row buffer starts clean for the next block.

Top module: `zz_corner_decoder`

## Requirements
- R1: Rows are numbered 0 to ROWS-1 from the top and columns 0 to COLS-1 from the left. Row 0 and every even-numbered row visit columns in ascending order; odd-numbered rows visit them in descending order, so each row starts at the column where the previous one ended.
- R2: The fill flag is taken as 0 for the first symbol of every row, whatever value it held at the end of the previous row.
- R3: A symbol value of 1 toggles the fill flag; a value of 0 leaves it unchanged.
- R4: For each symbol at column c, the new fill value (after any toggle) is XORed into row buffer bit c; the output pixel equals the updated bit, and the bit keeps that value for the next row.
- R5: The row buffer is all zeros after reset and again after the last symbol of every block, so each block decodes independently of the previous one.
- R6: pix_eob is 1 on the output beat of the last position of a block (row ROWS-1, column 0 when ROWS is even, COLS-1 when odd) and 0 on every other beat.
- R7: Each accepted symbol produces exactly one output beat, valid in the cycle after acceptance; sym_ready is 1 whenever the output stage is empty or pix_ready is 1.
- R8: While pix_valid is 1 and pix_ready is 0, no symbol is accepted and pix_on, pix_col, pix_row and pix_eob hold their values.
- R9: During and right after reset, pix_valid is 0 and sym_ready is 1, and decoding restarts at row 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | A corner symbol is offered |
| sym_ready | output | 1 | The decoder takes the offered symbol this cycle |
| sym_corner | input | 1 | Symbol value: 1 marks a transitional corner |
| pix_valid | output | 1 | An output pixel beat is present |
| pix_ready | input | 1 | The beam driver takes the present beat |
| pix_on | output | 1 | Decoded pixel value |
| pix_col | output | $clog2(COLS) | Column of the pixel |
| pix_row | output | $clog2(ROWS) | Row of the pixel |
| pix_eob | output | 1 | Last pixel of the block |

## Verification
The end of a row and the end of a block coincide on the final symbol, in the same cycle that the buffer write for that column would land and the buffer clear must win; blocks that leave the buffer full are followed at once by blocks of zeros so that any leftover bit shows up as a wrong pixel. Likewise a corner on the last column of a row collides with the forced fill reset of the next row's first symbol, provoked by patterns that leave the flag set at a row end. Stall patterns that drop pix_ready while symbols keep arriving make acceptance and output hold fall in the same cycle; every beat is compared against a bench model of the per-pixel rule and held beats are checked for stability.

// File: rtl/zzd_pkg.sv
`timescale 1ns/1ps
package zzd_pkg;

  // Scan direction of the current row.
  typedef enum logic {
    DIR_FWD = 1'b0,  // column index ascends
    DIR_REV = 1'b1   // column index descends
  } zz_dir_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/zz_cursor.sv
`timescale 1ns/1ps
module zz_cursor
  import zzd_pkg::*;
#(
  parameter int unsigned COLS = 8,
  parameter int unsigned ROWS = 4,
  localparam int unsigned CW = idx_width(COLS),
  localparam int unsigned RW = idx_width(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic          row_first,
  output logic          row_last,
  output logic          blk_last
);

  localparam logic [CW-1:0] COL_MAX = CW'(COLS - 1);
  localparam logic [RW-1:0] ROW_MAX = RW'(ROWS - 1);

  logic [CW-1:0] col_q, col_d;
  logic [RW-1:0] row_q, row_d;
  zz_dir_e       dir_q, dir_d;

  always_comb begin
    if (dir_q == DIR_FWD) begin
      row_first = (col_q == '0);
      row_last  = (col_q == COL_MAX);
    end else begin
      row_first = (col_q == COL_MAX);
      row_last  = (col_q == '0);
    end
    blk_last = row_last && (row_q == ROW_MAX);
  end

  always_comb begin
    col_d = col_q;
    row_d = row_q;
    dir_d = dir_q;
    if (adv) begin
      if (blk_last) begin
        col_d = '0;
        row_d = '0;
        dir_d = DIR_FWD;
      end else if (row_last) begin
        row_d = row_q + 1'b1;
        dir_d = (dir_q == DIR_FWD) ? DIR_REV : DIR_FWD;
      end else if (dir_q == DIR_FWD) begin
        col_d = col_q + 1'b1;
      end else begin
        col_d = col_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
      dir_q <= DIR_FWD;
    end else if (adv) begin
      col_q <= col_d;
      row_q <= row_d;
      dir_q <= dir_d;
    end
  end

  assign col = col_q;
  assign row = row_q;

endmodule

// File: rtl/zz_fill.sv
`timescale 1ns/1ps
module zz_fill (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic row_first,
  input  logic corner,
  output logic fill_now
);

  logic fill_q;
  logic fill_base;

  always_comb begin
    fill_base = row_first ? 1'b0 : fill_q;
    fill_now  = fill_base ^ corner;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= 1'b0;
    end else if (take) begin
      fill_q <= fill_now;
    end
  end

endmodule

// File: rtl/zz_rowbuf.sv
`timescale 1ns/1ps
module zz_rowbuf
  import zzd_pkg::*;
#(
  parameter int unsigned COLS = 8,
  localparam int unsigned CW = idx_width(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          clr,
  input  logic [CW-1:0] addr,
  input  logic          wdata,
  output logic          rdata
);

  logic [COLS-1:0] bits_q;

  generate
    for (genvar i = 0; i < COLS; i++) begin : g_bit
      logic bit_en;
      logic bit_d;
      always_comb begin
        bit_en = clr || (wr && (addr == CW'(i)));
        bit_d  = clr ? 1'b0 : wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bits_q[i] <= 1'b0;
        end else if (bit_en) begin
          bits_q[i] <= bit_d;
        end
      end
    end
  endgenerate

  assign rdata = bits_q[addr];

endmodule

// File: rtl/zz_corner_decoder.sv
`timescale 1ns/1ps
module zz_corner_decoder
  import zzd_pkg::*;
#(
  parameter int unsigned COLS = 8,
  parameter int unsigned ROWS = 4,
  localparam int unsigned CW = idx_width(COLS),
  localparam int unsigned RW = idx_width(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sym_valid,
  output logic          sym_ready,
  input  logic          sym_corner,
  output logic          pix_valid,
  input  logic          pix_ready,
  output logic          pix_on,
  output logic [CW-1:0] pix_col,
  output logic [RW-1:0] pix_row,
  output logic          pix_eob
);

  logic          take;
  logic [CW-1:0] cur_col;
  logic [RW-1:0] cur_row;
  logic          row_first, row_last, blk_last;
  logic          fill_now;
  logic          buf_bit;
  logic          pix_new;

  logic          vld_q, vld_d;
  logic          on_q, on_d;
  logic [CW-1:0] col_q, col_d;
  logic [RW-1:0] row_q, row_d;
  logic          eob_q, eob_d;
  logic          out_en;

  assign sym_ready = !vld_q || pix_ready;
  assign take      = sym_valid && sym_ready;

  zz_cursor #(.COLS(COLS), .ROWS(ROWS)) u_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (take),
    .col       (cur_col),
    .row       (cur_row),
    .row_first (row_first),
    .row_last  (row_last),
    .blk_last  (blk_last)
  );

  zz_fill u_fill (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .row_first (row_first),
    .corner    (sym_corner),
    .fill_now  (fill_now)
  );

  assign pix_new = buf_bit ^ fill_now;

  zz_rowbuf #(.COLS(COLS)) u_rowbuf (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (take),
    .clr   (take && blk_last),
    .addr  (cur_col),
    .wdata (pix_new),
    .rdata (buf_bit)
  );

  // Output stage next state
  always_comb begin
    out_en = take || (vld_q && pix_ready);
    vld_d  = take;
    on_d   = on_q;
    col_d  = col_q;
    row_d  = row_q;
    eob_d  = eob_q;
    if (take) begin
      on_d  = pix_new;
      col_d = cur_col;
      row_d = cur_row;
      eob_d = blk_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      on_q  <= 1'b0;
      col_q <= '0;
      row_q <= '0;
      eob_q <= 1'b0;
    end else if (out_en) begin
      vld_q <= vld_d;
      on_q  <= on_d;
      col_q <= col_d;
      row_q <= row_d;
      eob_q <= eob_d;
    end
  end

  assign pix_valid = vld_q;
  assign pix_on    = on_q;
  assign pix_col   = col_q;
  assign pix_row   = row_q;
  assign pix_eob   = eob_q;

  logic unused_row_last;
  assign unused_row_last = row_last;

endmodule

// File: rtl/zzd_checker.sv
`timescale 1ns/1ps
module zzd_checker
  import zzd_pkg::*;
#(
  parameter int unsigned COLS = 8,
  parameter int unsigned ROWS = 4,
  localparam int unsigned CW = idx_width(COLS),
  localparam int unsigned RW = idx_width(ROWS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sym_valid,
  input logic          sym_ready,
  input logic          pix_valid,
  input logic          pix_ready,
  input logic          pix_on,
  input logic [CW-1:0] pix_col,
  input logic [RW-1:0] pix_row,
  input logic          pix_eob
);

  localparam logic [CW-1:0] COL_MAX = CW'(COLS - 1);
  localparam logic [RW-1:0] ROW_MAX = RW'(ROWS - 1);
  localparam logic [CW-1:0] END_COL = ((ROWS % 2) == 0) ? '0 : COL_MAX;

  AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (pix_col <= COL_MAX)); // R1

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && $past(pix_valid && pix_ready) && (pix_row == $past(pix_row)))
      |-> (pix_col == (pix_row[0] ? ($past(pix_col) - 1'b1) : ($past(pix_col) + 1'b1)))); // R1

  AST_EOB_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_eob) |-> ((pix_row == ROW_MAX) && (pix_col == END_COL))); // R6

  AST_BEAT_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_ready) |=> pix_valid); // R7

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_ready |-> pix_valid); // R7

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_on) && $stable(pix_col)
                                   && $stable(pix_row) && $stable(pix_eob))); // R8

endmodule

bind zz_corner_decoder zzd_checker #(.COLS(COLS), .ROWS(ROWS)) u_zzd_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .sym_valid (sym_valid),
  .sym_ready (sym_ready),
  .pix_valid (pix_valid),
  .pix_ready (pix_ready),
  .pix_on    (pix_on),
  .pix_col   (pix_col),
  .pix_row   (pix_row),
  .pix_eob   (pix_eob)
);

// File: tb/tb_zz_corner_decoder.sv
`timescale 1ns/1ps
module tb_zz_corner_decoder;

  localparam int COLS = 8;
  localparam int ROWS = 4;
  localparam int N    = COLS * ROWS;
  localparam int CW   = $clog2(COLS);
  localparam int RW   = $clog2(ROWS);
  localparam int NVEC = 8;

  // {mode[1:0], symbols[31:0]}; symbol bit k is the k-th symbol in stream order.
  // mode 0: no stalls, 1: pix_ready drops, 2: gaps in sym_valid
  localparam logic [33:0] VEC [NVEC] = '{
    {2'd0, 32'h0000_0024},  // R4 box open/close in row 0
    {2'd0, 32'h0000_0008},  // R4 single corner leaves buffer full
    {2'd0, 32'h0000_0000},  // R5 zero block after full buffer
    {2'd1, 32'h4000_0040},  // R2 fill left set at row end
    {2'd1, 32'hFFFF_FFFF},  // R3 toggles every symbol
    {2'd2, 32'hA5A5_3C3C},
    {2'd2, 32'h0100_8001},  // R1 corners at row ends
    {2'd1, 32'h8000_0001}   // R6 corner on the final position
  };

  logic          clk;
  logic          rst_n;
  logic          sym_valid;
  logic          sym_ready;
  logic          sym_corner;
  logic          pix_valid;
  logic          pix_ready;
  logic          pix_on;
  logic [CW-1:0] pix_col;
  logic [RW-1:0] pix_row;
  logic          pix_eob;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  zz_corner_decoder #(.COLS(COLS), .ROWS(ROWS)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_valid  (sym_valid),
    .sym_ready  (sym_ready),
    .sym_corner (sym_corner),
    .pix_valid  (pix_valid),
    .pix_ready  (pix_ready),
    .pix_on     (pix_on),
    .pix_col    (pix_col),
    .pix_row    (pix_row),
    .pix_eob    (pix_eob)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(input int k);
    int r = k / COLS;
    int j = k % COLS;
    return (r % 2 == 1) ? (COLS - 1 - j) : j;
  endfunction

  // Reference: pixel k per the per-symbol rule of the requirements.
  function automatic logic [N-1:0] model(input logic [N-1:0] s);
    logic [COLS-1:0] b = '0;
    logic [N-1:0]    p = '0;
    logic            f = 1'b0;
    for (int k = 0; k < N; k++) begin
      int c = exp_col(k);
      if (k % COLS == 0) f = 1'b0;
      f = f ^ s[k];
      b[c] = b[c] ^ f;
      p[k] = b[c];
    end
    return p;
  endfunction

  task automatic run_block(input logic [N-1:0] s, input logic [1:0] mode);
    logic [N-1:0] ep = model(s);
    int kin = 0;
    int kout = 0;
    int cyc = 0;
    bit held = 0;
    logic          h_on, h_eob;
    logic [CW-1:0] h_col;
    logic [RW-1:0] h_row;
    while (kout < N && cyc < 2000) begin
      @(negedge clk);
      pix_ready  = (mode == 2'd1) ? (cyc % 3 != 0) : 1'b1;
      sym_valid  = (kin < N) && ((mode == 2'd2) ? (cyc % 2 == 0) : 1'b1);
      sym_corner = (kin < N) ? s[kin] : 1'b0;
      #1;
      if (held) begin
        check(pix_valid && pix_on == h_on && pix_col == h_col && pix_row == h_row
              && pix_eob == h_eob, "R8 hold", int'(pix_col), int'(h_col));
        held = 0;
      end
      if (pix_valid && pix_ready) begin
        check(pix_on == ep[kout], "R4 pixel", int'(pix_on), int'(ep[kout]));
        check(int'(pix_col) == exp_col(kout) && int'(pix_row) == kout / COLS,
              "R1 position", int'(pix_row) * 100 + int'(pix_col),
              (kout / COLS) * 100 + exp_col(kout));
        check(pix_eob == (kout == N - 1), "R6 eob", int'(pix_eob), int'(kout == N - 1));
        kout++;
      end else if (pix_valid) begin
        h_on = pix_on; h_col = pix_col; h_row = pix_row; h_eob = pix_eob;
        held = 1;
        check(!sym_ready, "R8 no take", int'(sym_ready), 0);
      end
      if (sym_valid && sym_ready) kin++;
      cyc++;
    end
    check(kout == N && kin == N, "R7 beat count", kout, N);
    @(negedge clk);
    sym_valid = 1'b0;
    pix_ready = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; sym_valid = 1'b0; sym_corner = 1'b0; pix_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(!pix_valid, "R9 reset valid", int'(pix_valid), 0);
    check(sym_ready, "R9 reset ready", int'(sym_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!pix_valid && sym_ready, "R9 after reset", int'(pix_valid), 0);

    for (int v = 0; v < NVEC; v++) run_block(VEC[v][N-1:0], VEC[v][33:32]);

    // R7: idle input drains the output stage
    repeat (3) @(negedge clk);
    #1;
    check(!pix_valid, "R7 idle", int'(pix_valid), 0);

    // R5/R9: reset in mid-block leaves no trace
    @(negedge clk);
    sym_valid = 1'b1; sym_corner = 1'b1;
    @(negedge clk);
    sym_corner = 1'b0;
    repeat (10) @(negedge clk);
    sym_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    check(!pix_valid, "R9 mid reset", int'(pix_valid), 0);
    rst_n = 1'b1;
    run_block(32'h0000_0000, 2'd0);  // R5 all-zero after reset
    run_block(32'h0010_2400, 2'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule